// File: doc/BRIEF.md
# Transmit Frame Formatter

This block turns a payload held in a byte stream into a finished serial radio frame. A start command launches the frame. The block first sends a run of alternating bits as a preamble, then a synchronization pattern, then the payload bytes it pulls from a ready/valid byte source. It closes the frame with a 16-bit CRC. The bits go out one at a time toward a modulator, paced by a bit-clock enable that the modulator provides.

The preamble length and the sync pattern and its length are set on configuration inputs, and either part can be left out. The payload length is fixed by an input, or it is read from the first payload byte. The order of bits within each payload byte is selectable. Configuration is captured when the frame starts. If the byte source has nothing ready when a byte is needed, the frame is abandoned and an underflow pulse is raised.

Top module: `txfrm_fmt`

## Requirements
- R1: After reset, busy, tx_act, pay_ready, done and uflow are all low.
- R2: When pre_len is nonzero, the frame begins with pre_len bits that alternate, starting with 1 (1,0,1,0,...). When pre_len is 0, there is no preamble. pre_len ranges from 0 to 32.
- R3: When sync_en is high, the preamble is followed by the low sync_len bits of sync_word, sent from bit sync_len-1 down to bit 0. sync_len ranges from 8 to 32. When sync_en is low, no sync bits are sent.
- R4: pay_ready is first raised only after every preamble and sync bit has been consumed. It is never high while tx_act is high. Each byte handshake takes one clock cycle, during which tx_act is low.
- R5: With var_len low, exactly fix_len payload bytes are sent. A fix_len of 0 sends no payload and goes straight to the CRC.
- R6: With var_len high, the first payload byte holds N, and N more bytes follow it. A value of N=0 sends only the length byte.
- R7: With lsb_first low, each payload byte is sent from bit 7 down to bit 0. With lsb_first high, it is sent from bit 0 up to bit 7.
- R8: After the payload, 16 CRC bits are sent, most significant first, whatever the bit order of the payload. The CRC uses polynomial 0x1021 with initial value 0xFFFF. It covers every payload byte, including the length byte, and each byte enters the CRC most significant bit first. For the ASCII bytes "123456789", the CRC is 0x29B1.
- R9: A bit is consumed only in a cycle where both tx_act and bit_en are high. While tx_act is high and bit_en is low, tx_bit and tx_act hold their values into the next cycle.
- R10: If pay_valid is low in the cycle pay_ready is high, uflow pulses for one cycle in the next cycle. At that point the block is idle, no further bits are sent and done does not pulse.
- R11: done is high for exactly one cycle: the cycle that follows the clock edge that consumed the last CRC bit. The block is idle during that cycle, and a start in that same cycle launches a new frame.
- R12: start has no effect while busy is high. The frame in progress is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch a frame when idle |
| pre_len | input | LW (6) | Preamble length in bits, 0 to 32 |
| sync_en | input | 1 | Send the sync pattern |
| sync_len | input | LW (6) | Sync pattern length, 8 to 32 |
| sync_word | input | SYNC_W (32) | Sync pattern, right-aligned |
| var_len | input | 1 | Length taken from the first payload byte |
| fix_len | input | 8 | Payload byte count in fixed mode |
| lsb_first | input | 1 | Payload bit order select |
| pay_data | input | 8 | Payload byte from source |
| pay_valid | input | 1 | Source byte is valid |
| pay_ready | output | 1 | Block takes the byte this cycle |
| bit_en | input | 1 | Bit-clock enable from the modulator |
| tx_bit | output | 1 | Current serial bit |
| tx_act | output | 1 | tx_bit carries a frame bit |
| busy | output | 1 | Frame in progress |
| done | output | 1 | Frame completed pulse |
| uflow | output | 1 | Source underflow, frame aborted |

## Verification
Two events can fall in the same cycle: the end of one frame and the launch of the next. The done pulse arrives in the cycle where a new start can be accepted. The bench provokes this by raising start in exactly the cycle it predicts for done. It judges the result by checking three things: done appears one cycle after the last CRC bit, the second frame's bit stream matches in full, and no bits are lost or duplicated between the frames. A related collision is a bit enable landing in a byte-fetch cycle. Random enable densities provoke it, and the full stream comparison would expose any bit consumed there.

// File: rtl/txfrm_fmt.sv
`timescale 1ns/1ps
module txfrm_fmt #(
  parameter int SYNC_W  = 32,
  parameter int PRE_MAX = 32,
  parameter int LW      = $clog2((SYNC_W > PRE_MAX ? SYNC_W : PRE_MAX) + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [LW-1:0]     pre_len,
  input  logic              sync_en,
  input  logic [LW-1:0]     sync_len,
  input  logic [SYNC_W-1:0] sync_word,
  input  logic              var_len,
  input  logic [7:0]        fix_len,
  input  logic              lsb_first,
  input  logic [7:0]        pay_data,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic              bit_en,
  output logic              tx_bit,
  output logic              tx_act,
  output logic              busy,
  output logic              done,
  output logic              uflow
);
  typedef enum logic [2:0] {S_IDLE, S_PRE, S_SYNC, S_FETCH, S_PAY, S_CRC} st_t;

  st_t               st, nxt_pay, pay_at_start;
  logic [LW-1:0]     cnt, pl, sl;
  logic [SYNC_W-1:0] sh;
  logic [7:0]        dat, rem;
  logic [15:0]       crc;
  logic              sy, lsb, first, done_q, uflow_q;

  function automatic logic [15:0] crc_step(input logic [15:0] c, input logic [7:0] d);
    logic [15:0] r;
    r = c ^ {d, 8'h00};
    for (int i = 0; i < 8; i++)
      r = r[15] ? ({r[14:0], 1'b0} ^ 16'h1021) : {r[14:0], 1'b0};
    return r;
  endfunction

  assign nxt_pay      = (first || rem != 8'd0) ? S_FETCH : S_CRC;
  assign pay_at_start = (var_len || fix_len != 8'd0) ? S_FETCH : S_CRC;
  assign tx_act       = (st == S_PRE) || (st == S_SYNC) || (st == S_PAY) || (st == S_CRC);
  assign busy         = st != S_IDLE;
  assign pay_ready    = st == S_FETCH;
  assign done         = done_q;
  assign uflow        = uflow_q;

  always_comb begin
    case (st)
      S_PRE:   tx_bit = ~cnt[0];
      S_SYNC:  tx_bit = sh[SYNC_W-1];
      S_PAY:   tx_bit = lsb ? dat[cnt[2:0]] : dat[3'd7 - cnt[2:0]];
      S_CRC:   tx_bit = crc[4'd15 - cnt[3:0]];
      default: tx_bit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; pl <= '0; sl <= '0; sh <= '0;
      dat <= '0; rem <= '0; crc <= '1; sy <= 1'b0; lsb <= 1'b0;
      first <= 1'b0; done_q <= 1'b0; uflow_q <= 1'b0;
    end else begin
      done_q  <= 1'b0;
      uflow_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          pl    <= pre_len;
          sl    <= sync_len;
          sy    <= sync_en;
          lsb   <= lsb_first;
          sh    <= sync_word << (LW'(SYNC_W) - sync_len);
          first <= var_len;
          rem   <= var_len ? 8'd0 : fix_len;
          crc   <= 16'hFFFF;
          cnt   <= '0;
          st    <= (pre_len != '0) ? S_PRE : (sync_en ? S_SYNC : pay_at_start);
        end
        S_PRE: if (bit_en) begin
          cnt <= cnt + 1'b1;
          if (cnt == pl - 1'b1) begin
            cnt <= '0;
            st  <= sy ? S_SYNC : nxt_pay;
          end
        end
        S_SYNC: if (bit_en) begin
          sh  <= sh << 1;
          cnt <= cnt + 1'b1;
          if (cnt == sl - 1'b1) begin
            cnt <= '0;
            st  <= nxt_pay;
          end
        end
        S_FETCH: begin
          if (pay_valid) begin
            dat   <= pay_data;
            crc   <= crc_step(crc, pay_data);
            rem   <= first ? pay_data : rem - 8'd1;
            first <= 1'b0;
            cnt   <= '0;
            st    <= S_PAY;
          end else begin
            uflow_q <= 1'b1;
            st      <= S_IDLE;
          end
        end
        S_PAY: if (bit_en) begin
          cnt <= cnt + 1'b1;
          if (cnt[2:0] == 3'd7) begin
            cnt <= '0;
            st  <= nxt_pay;
          end
        end
        S_CRC: if (bit_en) begin
          cnt <= cnt + 1'b1;
          if (cnt[3:0] == 4'd15) begin
            cnt    <= '0;
            done_q <= 1'b1;
            st     <= S_IDLE;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module txfrm_fmt_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic bit_en,
  input logic pay_valid,
  input logic pay_ready,
  input logic tx_act,
  input logic tx_bit,
  input logic busy,
  input logic done,
  input logic uflow
);
  // R4
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pay_ready |-> !tx_act);
  // R9
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_act && !bit_en) |=> (tx_act && $stable(tx_bit)));
  // R10
  uflow_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_ready && !pay_valid) |=> uflow);
  // R10
  uflow_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uflow |-> (!busy && !done));
  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R11
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !tx_act));
  // R12
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && tx_act && !bit_en) |=> busy);
endmodule

bind txfrm_fmt txfrm_fmt_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start(start), .bit_en(bit_en),
  .pay_valid(pay_valid), .pay_ready(pay_ready), .tx_act(tx_act),
  .tx_bit(tx_bit), .busy(busy), .done(done), .uflow(uflow)
);

// File: tb/txfrm_fmt_tb_top.sv
`timescale 1ns/1ps
module txfrm_fmt_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [5:0] pre_len = '0, sync_len = 6'd8;
  logic sync_en = 1'b0, var_len = 1'b0, lsb_first = 1'b0;
  logic [31:0] sync_word = '0;
  logic [7:0] fix_len = '0, pay_data = '0;
  logic pay_valid = 1'b0, bit_en = 1'b0;
  logic pay_ready, tx_bit, tx_act, busy, done, uflow;

  int nchk = 0, nfail = 0, ne = 0, ng = 0;
  logic [7:0] mem [0:511];
  bit exp_b [0:4095];
  bit got_b [0:4095];

  always #2.5 clk = ~clk;

  txfrm_fmt dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .pre_len(pre_len),
    .sync_en(sync_en), .sync_len(sync_len), .sync_word(sync_word),
    .var_len(var_len), .fix_len(fix_len), .lsb_first(lsb_first),
    .pay_data(pay_data), .pay_valid(pay_valid), .pay_ready(pay_ready),
    .bit_en(bit_en), .tx_bit(tx_bit), .tx_act(tx_act), .busy(busy),
    .done(done), .uflow(uflow)
  );

  task automatic chk(input bit ok, input string r, input longint act, input longint expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", r, act, expv);
    end
  endtask

  task automatic push(input bit b);
    exp_b[ne] = b;
    ne++;
  endtask

  task automatic build(input int base, output int nb);
    logic [15:0] c;
    c = 16'hFFFF;
    for (int i = 0; i < int'(pre_len); i++) push(i % 2 == 0);
    if (sync_en) for (int i = int'(sync_len) - 1; i >= 0; i--) push(sync_word[i]);
    nb = var_len ? int'(mem[base]) + 1 : int'(fix_len);
    for (int k = 0; k < nb; k++) begin
      logic [7:0] b;
      b = mem[base + k];
      for (int i = 0; i < 8; i++) push(lsb_first ? b[i] : b[7 - i]);
      for (int i = 7; i >= 0; i--) begin
        logic fb;
        fb = c[15] ^ b[i];
        c = {c[14:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      end
    end
    for (int i = 15; i >= 0; i--) push(c[i]);
  endtask

  task automatic run(input int nfr, input int uf_at, input int dens, input bit spur, input string tag);
    int nb, base, cyc, lastcyc, dones, ufs, rdy_first, idx, hdr, nbytes, mism;
    int ends [2];
    bit restart, take, fin;
    ne = 0; ng = 0; base = 0; nbytes = 0;
    for (int f = 0; f < nfr; f++) begin
      build(base, nb);
      ends[f] = ne; base += nb; nbytes += nb;
    end
    hdr = int'(pre_len) + (sync_en ? int'(sync_len) : 0);
    start = 1'b0; bit_en = 1'b0; pay_valid = 1'b0;
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    cyc = 0; lastcyc = -10; dones = 0; ufs = 0; rdy_first = -1; idx = 0;
    restart = 0; take = 0; fin = 0;
    while (!fin && cyc < 20000) begin
      @(negedge clk);
      if (take) idx++;
      start = (cyc == 0) || restart || (spur && ng > 0 && ng < ne - 1 && ($urandom % 16 == 0));
      restart = 0;
      bit_en = ($urandom % 100) < dens;
      pay_valid = (idx != uf_at);
      pay_data = mem[idx];
      #1;
      if (pay_ready && rdy_first < 0) rdy_first = ng;
      if (done) begin
        dones++;
        chk(cyc == lastcyc + 1, {tag, " R11 done one cycle after last CRC bit"}, cyc, lastcyc + 1);
        if (dones == nfr) fin = 1;
      end
      if (uflow) begin ufs++; fin = 1; end
      if (bit_en && tx_act) begin
        if (ng < 4096) got_b[ng] = tx_bit;
        ng++;
        for (int f = 0; f < nfr; f++) if (ng == ends[f]) lastcyc = cyc;
        if (nfr == 2 && ng == ends[0]) restart = 1;
      end
      take = pay_ready && pay_valid;
      cyc++;
    end
    chk(cyc < 20000, {tag, " R11 frame finished before timeout"}, cyc, 20000);
    if (uf_at < 0) begin
      chk(ng == ne, {tag, " bit count"}, ng, ne);
      chk(dones == nfr && ufs == 0, {tag, " R11 done count"}, dones, nfr);
    end else begin
      chk(ng == hdr + 8 * uf_at, {tag, " R10 bits before abort"}, ng, hdr + 8 * uf_at);
      chk(ufs == 1 && dones == 0, {tag, " R10 underflow flagged, no done"}, ufs, 1);
      @(negedge clk);
      chk(!busy && !tx_act && !uflow, {tag, " R10 idle after abort"}, busy, 0);
    end
    mism = -1;
    for (int i = 0; i < ng && i < ne && i < 4096; i++)
      if (mism < 0 && got_b[i] != exp_b[i]) mism = i;
    chk(mism < 0, {tag, " stream mismatch at bit index (actual=index, expected=-1)"}, mism, -1);
    chk(rdy_first == ((nbytes == 0) ? -1 : hdr), {tag, " R4 first fetch after header"},
        rdy_first, (nbytes == 0) ? -1 : hdr);
  endtask

  initial begin
    #999000;
    nfail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [15:0] crcv;
    void'($urandom(32'h1F2E3D4C));
    repeat (3) @(negedge clk);
    #1;
    chk(!busy && !tx_act && !pay_ready && !done && !uflow, "R1 reset state", busy, 0);

    // R8 R5 known CRC vector
    for (int i = 0; i < 9; i++) mem[i] = 8'h31 + 8'(i);
    pre_len = 6'd8; sync_en = 1; sync_len = 6'd16; sync_word = 32'h0000_2DD4;
    var_len = 0; fix_len = 8'd9; lsb_first = 0;
    run(1, -1, 100, 0, "R2 R3 R5 R8 ascii");
    for (int i = 0; i < 16; i++) crcv[15 - i] = got_b[ng - 16 + i];
    chk(crcv == 16'h29B1, "R8 check value", crcv, 16'h29B1);

    // R2 R3 R5 R8: no preamble, no sync, no payload
    pre_len = 0; sync_en = 0; fix_len = 0;
    run(1, -1, 50, 0, "R5 R8 empty");
    chk(ng == 16, "R2 R3 only CRC bits", ng, 16);

    // R6 R7 max preamble and sync, lsb first
    mem[0] = 8'd3; mem[1] = 8'hA5; mem[2] = 8'h01; mem[3] = 8'h80;
    pre_len = 6'd32; sync_en = 1; sync_len = 6'd32; sync_word = 32'h9AC3_7E15;
    var_len = 1; lsb_first = 1;
    run(1, -1, 40, 0, "R2 R3 R6 R7 max header");

    // R6 length byte zero
    mem[0] = 8'd0; pre_len = 6'd1; sync_len = 6'd8; lsb_first = 0;
    run(1, -1, 70, 0, "R6 zero length");

    // R11 back-to-back frames: start during done cycle
    mem[0] = 8'd2; mem[1] = 8'h3C; mem[2] = 8'hF0; mem[3] = 8'd1; mem[4] = 8'h5A;
    pre_len = 6'd4; sync_len = 6'd12; sync_word = 32'h0000_0B47;
    run(2, -1, 100, 0, "R11 chained");

    // R10 underflow mid frame and on first fetch
    for (int i = 0; i < 8; i++) mem[i] = 8'($urandom);
    var_len = 0; fix_len = 8'd5; lsb_first = 1;
    run(1, 2, 60, 0, "R10 mid");
    run(1, 0, 60, 0, "R10 first");

    // random frames with spurious starts (R12) and varied enable density (R9)
    for (int n = 0; n < 20; n++) begin
      pre_len   = 6'($urandom_range(0, 32));
      sync_en   = 1'($urandom);
      sync_len  = 6'($urandom_range(8, 32));
      sync_word = $urandom;
      var_len   = 1'($urandom);
      lsb_first = 1'($urandom);
      fix_len   = 8'($urandom_range(0, 12));
      for (int i = 0; i < 16; i++) mem[i] = 8'($urandom);
      mem[0] = var_len ? 8'($urandom_range(0, 12)) : mem[0];
      run(1, -1, $urandom_range(20, 100), 1, "R5 R6 R7 R9 R12 random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule